// File: doc/BRIEF.md
# Hermitian Symmetry Frame Builder and Remover

This block prepares the frequency-domain input of an N-point inverse transform so that the time-domain result has no imaginary part. That property is needed when the signal drives a light source by intensity. Complex constellation symbols arrive on a ready/valid stream. After N/2-1 of them have been collected, the block emits one complete N-bin frame in natural bin order. Bin 0 (DC) and bin N/2 are zero. Bins 1 to N/2-1 carry the symbols in the order they arrived. Every bin k above N/2 carries the complex conjugate of bin N-k.

A companion path on the receive side takes a frame of N bins after the forward transform. It drops the DC bin, the Nyquist bin and the whole conjugate half, and passes on only bins 1 to N/2-1 as a symbol stream. Feeding the builder output into the remover returns the original symbols. The transform, cyclic prefix and constellation mapping sit outside this block.

Top module: `hfb_top`

## Requirements
- R1: After reset, and on the first clock after reset is released, the symbol input is ready, and neither the frame output nor the symbol output is valid.
- R2: The builder accepts exactly N/2-1 symbols, then holds `sym_ready` low until all N bins of the frame have been accepted downstream. Symbols offered while `sym_ready` is low are not taken.
- R3: Bin 0 and bin N/2 of every output frame have both components equal to zero.
- R4: Bin k, for 1 <= k <= N/2-1, carries the k-th accepted symbol of the frame, counting from 1, unchanged.
- R5: Bin N-k, for 1 <= k <= N/2-1, has the real part of bin k and the two's-complement negation of its imaginary part.
- R6: When the imaginary part of a mirrored symbol is the most negative value (16'h8000 at W=16), the conjugate bin carries the most positive value (16'h7FFF).
- R7: `bin_last` is high on bin N-1 of each frame and low on every other bin.
- R8: While `bin_valid` is high and `bin_ready` is low, the frame output keeps valid, data and last unchanged into the next cycle.
- R9: The remover passes only frame bins 1 to N/2-1, in order, to its symbol output, and raises `dout_last` with bin N/2-1. Its bin count restarts after a bin that arrives with `fin_last` high.
- R10: On a bin that is passed on, `fin_ready` equals `dout_ready`. On a dropped bin, `fin_ready` is high and `dout_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Input symbol valid |
| sym_ready | output | 1 | Builder can take a symbol |
| sym_re | input | W | Symbol real part, two's complement |
| sym_im | input | W | Symbol imaginary part, two's complement |
| bin_valid | output | 1 | Frame bin valid |
| bin_ready | input | 1 | Downstream takes the frame bin |
| bin_re | output | W | Frame bin real part |
| bin_im | output | W | Frame bin imaginary part |
| bin_last | output | 1 | Final bin of the frame |
| fin_valid | input | 1 | Received frame bin valid |
| fin_ready | output | 1 | Remover takes the received bin |
| fin_re | input | W | Received bin real part |
| fin_im | input | W | Received bin imaginary part |
| fin_last | input | 1 | Received final bin of the frame |
| dout_valid | output | 1 | Recovered symbol valid |
| dout_ready | input | 1 | Downstream takes the recovered symbol |
| dout_re | output | W | Recovered symbol real part |
| dout_im | output | W | Recovered symbol imaginary part |
| dout_last | output | 1 | Last data symbol of the frame |

## Verification
The checker counts bins from the handshakes it sees at the ports. Its bin positions are valid only if the remover's input frames are N bins long, or end with `fin_last` at their true end. The bench loops the builder output into the remover, so the frames it feeds are always aligned and complete. The bench gates that loop with a stall pattern and stalls the symbol output on its own schedule, so the stability and backpressure properties are exercised with the downstream side unready. Symbols are offered with idle gaps. A run of junk symbols is also offered while the builder is emitting, and the later frame contents are used to show that none of them was taken.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
   typedef enum logic {
      HFB_FILL = 1'b0,
      HFB_EMIT = 1'b1
   } hfb_phase_e;
endpackage

// File: rtl/hfb_conj.sv
module hfb_conj #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic [W-1:0] im_in,
   output logic [W-1:0] im_out
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   generate
      if (SAT) begin : g_sat
         always_comb begin
            if (im_in == MOST_NEG) im_out = MOST_POS;
            else                   im_out = -im_in;
         end
      end else begin : g_wrap
         always_comb im_out = -im_in;
      end
   endgenerate
endmodule

// File: rtl/hfb_builder.sv
module hfb_builder
   import hfb_pkg::*;
#(
   parameter int N_PT    = 64,
   parameter int W       = 16,
   parameter bit SAT_NEG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_re,
   input  logic [W-1:0] s_im,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_re,
   output logic [W-1:0] m_im,
   output logic         m_last
);
   localparam int HALF  = N_PT / 2;
   localparam int BIN_W = $clog2(N_PT);
   localparam int SYM_W = BIN_W - 1;
   localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(N_PT - 1);
   localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(HALF - 2);

   hfb_phase_e       phase;
   logic [SYM_W-1:0] fill_cnt;
   logic [BIN_W-1:0] bin_cnt;
   logic [W-1:0]     mem_re [HALF];
   logic [W-1:0]     mem_im [HALF];

   logic             upper;
   logic             zero_bin;
   logic [SYM_W-1:0] slot;
   logic [W-1:0]     rd_re;
   logic [W-1:0]     rd_im;
   logic [W-1:0]     neg_im;

   assign s_ready = (phase == HFB_FILL);
   assign m_valid = (phase == HFB_EMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= HFB_FILL;
         fill_cnt <= '0;
         bin_cnt  <= '0;
      end else if (phase == HFB_FILL) begin
         if (s_valid) begin
            if (fill_cnt == LAST_SYM) begin
               fill_cnt <= '0;
               phase    <= HFB_EMIT;
            end else begin
               fill_cnt <= fill_cnt + 1'b1;
            end
         end
      end else if (m_ready) begin
         if (bin_cnt == LAST_BIN) begin
            bin_cnt <= '0;
            phase   <= HFB_FILL;
         end else begin
            bin_cnt <= bin_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (phase == HFB_FILL && s_valid) begin
         mem_re[fill_cnt] <= s_re;
         mem_im[fill_cnt] <= s_im;
      end
   end

   // lower half reads slot k-1; upper half reads slot N-1-k, which is ~k in the low bits
   assign upper    = bin_cnt[BIN_W-1];
   assign zero_bin = (bin_cnt[SYM_W-1:0] == '0);
   assign slot     = upper ? ~bin_cnt[SYM_W-1:0] : (bin_cnt[SYM_W-1:0] - 1'b1);
   assign rd_re    = mem_re[slot];
   assign rd_im    = mem_im[slot];

   hfb_conj #(.W(W), .SAT(SAT_NEG)) u_conj (
      .im_in  (rd_im),
      .im_out (neg_im)
   );

   always_comb begin
      if (zero_bin) begin
         m_re = '0;
         m_im = '0;
      end else begin
         m_re = rd_re;
         m_im = upper ? neg_im : rd_im;
      end
   end

   assign m_last = m_valid && (bin_cnt == LAST_BIN);
endmodule

// File: rtl/hfb_remover.sv
module hfb_remover #(
   parameter int N_PT = 64,
   parameter int W    = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_re,
   input  logic [W-1:0] s_im,
   input  logic         s_last,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_re,
   output logic [W-1:0] m_im,
   output logic         m_last
);
   localparam int BIN_W = $clog2(N_PT);
   localparam int SYM_W = BIN_W - 1;

   logic [BIN_W-1:0] bin_cnt;
   logic             keep;

   assign keep    = !bin_cnt[BIN_W-1] && (bin_cnt[SYM_W-1:0] != '0);
   assign s_ready = keep ? m_ready : 1'b1;
   assign m_valid = s_valid && keep;
   assign m_re    = s_re;
   assign m_im    = s_im;
   assign m_last  = keep && (bin_cnt[SYM_W-1:0] == '1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bin_cnt <= '0;
      end else if (s_valid && s_ready) begin
         bin_cnt <= s_last ? '0 : bin_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hfb_top.sv
module hfb_top #(
   parameter int N_PT    = 64,
   parameter int W       = 16,
   parameter bit SAT_NEG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sym_valid,
   output logic         sym_ready,
   input  logic [W-1:0] sym_re,
   input  logic [W-1:0] sym_im,
   output logic         bin_valid,
   input  logic         bin_ready,
   output logic [W-1:0] bin_re,
   output logic [W-1:0] bin_im,
   output logic         bin_last,
   input  logic         fin_valid,
   output logic         fin_ready,
   input  logic [W-1:0] fin_re,
   input  logic [W-1:0] fin_im,
   input  logic         fin_last,
   output logic         dout_valid,
   input  logic         dout_ready,
   output logic [W-1:0] dout_re,
   output logic [W-1:0] dout_im,
   output logic         dout_last
);
   generate
      if (N_PT < 8 || (N_PT & (N_PT - 1)) != 0) begin : g_bad_size
         $error("hfb_top: N_PT must be a power of two of at least 8");
      end
      if (W < 2) begin : g_bad_width
         $error("hfb_top: W must be at least 2");
      end
   endgenerate

   hfb_builder #(.N_PT(N_PT), .W(W), .SAT_NEG(SAT_NEG)) u_build (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (sym_valid),
      .s_ready (sym_ready),
      .s_re    (sym_re),
      .s_im    (sym_im),
      .m_valid (bin_valid),
      .m_ready (bin_ready),
      .m_re    (bin_re),
      .m_im    (bin_im),
      .m_last  (bin_last)
   );

   hfb_remover #(.N_PT(N_PT), .W(W)) u_strip (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (fin_valid),
      .s_ready (fin_ready),
      .s_re    (fin_re),
      .s_im    (fin_im),
      .s_last  (fin_last),
      .m_valid (dout_valid),
      .m_ready (dout_ready),
      .m_re    (dout_re),
      .m_im    (dout_im),
      .m_last  (dout_last)
   );
endmodule

// File: rtl/hfb_chk.sv
module hfb_chk #(
   parameter int N_PT = 64,
   parameter int W    = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sym_ready,
   input logic         bin_valid,
   input logic         bin_ready,
   input logic [W-1:0] bin_re,
   input logic [W-1:0] bin_im,
   input logic         bin_last,
   input logic         fin_valid,
   input logic         fin_ready,
   input logic         fin_last,
   input logic         dout_valid,
   input logic         dout_ready,
   input logic         dout_last
);
   localparam int BIN_W = $clog2(N_PT);
   localparam logic [BIN_W-1:0] MID_BIN  = BIN_W'(N_PT / 2);
   localparam logic [BIN_W-1:0] TOP_DATA = BIN_W'(N_PT / 2 - 1);
   localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(N_PT - 1);

   logic [BIN_W-1:0] ocnt;
   logic [BIN_W-1:0] icnt;
   logic             in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ocnt <= '0;
         icnt <= '0;
      end else begin
         if (bin_valid && bin_ready) ocnt <= ocnt + 1'b1;
         if (fin_valid && fin_ready) icnt <= fin_last ? '0 : icnt + 1'b1;
      end
   end

   assign in_data = (icnt != '0) && (icnt <= TOP_DATA);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> sym_ready && !bin_valid && !dout_valid); // R1
   AST_NO_FILL_DURING_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bin_valid |-> !sym_ready); // R2
   AST_ZERO_BINS: assert property (@(posedge clk) disable iff (!rst_n)
      bin_valid && (ocnt == '0 || ocnt == MID_BIN) |-> bin_re == '0 && bin_im == '0); // R3
   AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
      bin_valid |-> bin_last == (ocnt == LAST_BIN)); // R7
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bin_valid && !bin_ready |=> bin_valid && $stable(bin_re) && $stable(bin_im) && $stable(bin_last)); // R8
   AST_STRIP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid && dout_last |-> icnt == TOP_DATA); // R9
   AST_STRIP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid && !in_data |-> fin_ready && !dout_valid); // R10
   AST_STRIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid && in_data |-> dout_valid && (fin_ready == dout_ready)); // R10
endmodule

bind hfb_top hfb_chk #(.N_PT(N_PT), .W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sym_ready  (sym_ready),
   .bin_valid  (bin_valid),
   .bin_ready  (bin_ready),
   .bin_re     (bin_re),
   .bin_im     (bin_im),
   .bin_last   (bin_last),
   .fin_valid  (fin_valid),
   .fin_ready  (fin_ready),
   .fin_last   (fin_last),
   .dout_valid (dout_valid),
   .dout_ready (dout_ready),
   .dout_last  (dout_last)
);

// File: tb/test_hfb_top.sv
module test_hfb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 64;
   localparam int HALF = N / 2;
   localparam int ND   = HALF - 1;
   localparam int W    = 16;
   localparam int NPAT = 4;
   // each entry: {base_re, step_re, base_im, step_im}; symbol i = base + i*step
   localparam logic [63:0] PATS [NPAT] = '{
      64'h0001_0001_0100_FFFF,
      64'h7FF0_0001_8000_0000,
      64'h8000_0400_7FFF_F000,
      64'h1234_0101_8001_0001
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_valid = 1'b0;
   logic [W-1:0] sym_re = '0, sym_im = '0;
   logic sym_ready;
   logic bin_valid, bin_ready, bin_last;
   logic [W-1:0] bin_re, bin_im;
   logic fin_valid, fin_ready, fin_last;
   logic [W-1:0] fin_re, fin_im;
   logic dout_valid, dout_last;
   logic dout_ready = 1'b1;
   logic [W-1:0] dout_re, dout_im;
   logic go = 1'b1;
   logic hold = 1'b0;

   int checks = 0, errors = 0;
   int cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign fin_valid = bin_valid && go;
   assign bin_ready = fin_ready && go;
   assign fin_re    = bin_re;
   assign fin_im    = bin_im;
   assign fin_last  = bin_last;

   hfb_top #(.N_PT(N), .W(W)) i_hfb_top (
      .clk(clk), .rst_n(rst_n),
      .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_re(sym_re), .sym_im(sym_im),
      .bin_valid(bin_valid), .bin_ready(bin_ready), .bin_re(bin_re), .bin_im(bin_im),
      .bin_last(bin_last),
      .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_re(fin_re), .fin_im(fin_im),
      .fin_last(fin_last),
      .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_re(dout_re),
      .dout_im(dout_im), .dout_last(dout_last)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sym_val(int p, int i);
      logic [15:0] re, im;
      re = PATS[p][63:48] + 16'(i) * PATS[p][47:32];
      im = PATS[p][31:16] + 16'(i) * PATS[p][15:0];
      return {re, im};
   endfunction

   function automatic logic [15:0] neg_sat(logic [15:0] v);
      return (v == 16'h8000) ? 16'h7FFF : 16'(-v);
   endfunction

   // stall pattern driver
   initial begin
      forever begin
         @(posedge clk); #1;
         cyc++;
         go         = !hold && (cyc % 5 != 3);
         dout_ready = (cyc % 7 != 2);
      end
   end

   // monitor
   logic [31:0] got [N];
   logic        got_last [N];
   logic [31:0] rem [ND];
   logic        rem_last [ND];
   int bcnt = 0, ocnt = 0, rin = 0;
   logic        prev_stall = 1'b0;
   logic [32:0] prev_bin = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         bcnt = 0; ocnt = 0; rin = 0; prev_stall = 1'b0;
      end else begin
         if (prev_stall)  // R8
            chk(bin_valid && {bin_last, bin_re, bin_im} == prev_bin, "R8 hold",
                {bin_re, bin_im}, prev_bin[31:0]);
         prev_stall = bin_valid && !bin_ready;
         prev_bin   = {bin_last, bin_re, bin_im};
         if (fin_valid) begin  // R10
            logic exp_rdy;
            exp_rdy = (rin != 0 && rin < HALF) ? dout_ready : 1'b1;
            chk(fin_ready == exp_rdy, "R10 fin_ready", 32'(fin_ready), 32'(exp_rdy));
            if (!(rin != 0 && rin < HALF))
               chk(!dout_valid, "R10 drop", 32'(dout_valid), 32'd0);
         end
         if (bin_valid && bin_ready && bcnt < N) begin
            got[bcnt] = {bin_re, bin_im};
            got_last[bcnt] = bin_last;
            bcnt++;
         end
         if (fin_valid && fin_ready) rin = fin_last ? 0 : rin + 1;
         if (dout_valid && dout_ready && ocnt < ND) begin
            rem[ocnt] = {dout_re, dout_im};
            rem_last[ocnt] = dout_last;
            ocnt++;
         end
      end
   end

   task automatic send_syms(int p, int cnt);
      for (int i = 0; i < cnt; i++) begin
         bit acc;
         if (i % 4 == 3) begin
            sym_valid = 1'b0;
            @(posedge clk); #1;
         end
         sym_valid = 1'b1;
         {sym_re, sym_im} = sym_val(p, i);
         acc = 1'b0;
         while (!acc) begin
            @(negedge clk);
            acc = sym_ready;
            @(posedge clk); #1;
         end
      end
      sym_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (!(bcnt == N && ocnt == ND)) @(posedge clk);
      @(posedge clk); #1;
   endtask

   task automatic check_frame(int p);
      for (int k = 0; k < N; k++) begin
         logic [31:0] e, s;
         if (k == 0 || k == HALF) begin
            chk(got[k] == 32'd0, "R3 zero bin", got[k], 32'd0);
         end else if (k < HALF) begin
            e = sym_val(p, k - 1);
            chk(got[k] == e, "R4 data bin", got[k], e);
         end else begin
            s = sym_val(p, N - 1 - k);
            e = {s[31:16], neg_sat(s[15:0])};
            if (s[15:0] == 16'h8000) chk(got[k] == e, "R6 saturated conj", got[k], e);
            else                     chk(got[k] == e, "R5 conj bin", got[k], e);
         end
         chk(got_last[k] == (k == N - 1), "R7 last", 32'(got_last[k]), 32'(k == N - 1));
      end
      for (int k = 1; k < HALF; k++) begin  // R5 Hermitian relation on observed bins
         logic [31:0] m;
         m = {got[k][31:16], neg_sat(got[k][15:0])};
         chk(got[N - k] == m, "R5 hermitian", got[N - k], m);
      end
      for (int i = 0; i < ND; i++) begin  // R9 round trip
         chk(rem[i] == sym_val(p, i), "R9 strip data", rem[i], sym_val(p, i));
         chk(rem_last[i] == (i == ND - 1), "R9 strip last", 32'(rem_last[i]), 32'(i == ND - 1));
      end
      bcnt = 0; ocnt = 0;
   endtask

   task automatic check_idle();  // R1
      @(negedge clk);
      chk(sym_ready, "R1 sym_ready", 32'(sym_ready), 32'd1);
      chk(!bin_valid, "R1 bin_valid", 32'(bin_valid), 32'd0);
      chk(!dout_valid, "R1 dout_valid", 32'(dout_valid), 32'd0);
      @(posedge clk); #1;
   endtask

   task automatic run_all();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_idle();
      for (int p = 0; p < NPAT; p++) begin
         send_syms(p, ND);
         wait_done();
         check_frame(p);
      end
      // R2: output blocked, extra symbols must not be taken
      hold = 1'b1;
      send_syms(0, ND);
      repeat (4) @(posedge clk);
      #1 sym_valid = 1'b1;
      {sym_re, sym_im} = 32'hDEAD_BEEF;
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         chk(!sym_ready, "R2 full", 32'(sym_ready), 32'd0);
         chk(bin_valid, "R2 emitting", 32'(bin_valid), 32'd1);
         @(posedge clk); #1;
      end
      sym_valid = 1'b0;
      hold = 1'b0;
      wait_done();
      check_frame(0);
      @(negedge clk);
      chk(sym_ready, "R2 refill", 32'(sym_ready), 32'd1);
      @(posedge clk); #1;
      // R1: reset in the middle of a fill
      send_syms(2, 10);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      check_idle();
      send_syms(3, ND);
      wait_done();
      check_frame(3);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule